// File: doc/BRIEF.md
# Spread-Spectrum Physical Header Receive Checker

This block sits behind the bit recovery stage of a frequency-hopping radio receiver. It takes the recovered serial bit stream, qualified by a valid flag, and hunts for a 16-bit start-of-frame delimiter. Once the delimiter is found, it collects the 32 header bits that follow. These are a 12-bit payload length, a 4-bit rate code and a 16-bit check word. It runs them through a serial CRC and judges the header.

A good header produces a one-cycle good pulse. At the same edge the block updates its registered length, rate and payload-bit-count outputs, and a downstream payload counter loads the bit count from those outputs. A header that fails the residue test, or that carries an unknown rate code, produces a one-cycle bad pulse and leaves the field outputs untouched. After any header, good or bad, the block returns to delimiter hunting.

Top module: `plcp_hdr_rx`

## Requirements
- R1: After reset, hdr_good and hdr_bad are low, pay_len, arm_bits and rate_2m are zero, and the block is hunting for the delimiter.
- R2: The delimiter is 16'h0CBD, compared over the last 16 valid bits with the first received bit as the MSB. The alternating preamble and other non-matching streams produce no flag.
- R3: The 32 valid bits after the delimiter are taken in this order: the length field (12 bits, MSB first), then the rate code (4 bits, leftmost bit first), then the check word (16 bits, MSB first).
- R4: The CRC register is preset to all ones at the first header bit. It divides by x^16+x^12+x^5+1 (0x1021, MSB-first serial form) over all 32 header bits. The header passes the check only if the final register equals 16'h1D0F.
- R5: Rate code 4'b0000 gives rate_2m=0 (1 Mbps) and 4'b0010 gives rate_2m=1 (2 Mbps). Any other code makes the header bad even if the check passes.
- R6: Exactly one of hdr_good or hdr_bad pulses for one cycle. The pulse starts on the clock edge that samples the 32nd header bit. The two flags are never high together.
- R7: On a good header, pay_len takes the length field, rate_2m takes the rate, and arm_bits takes length times 8. These outputs change only with hdr_good, so a bad header leaves them holding the last good values.
- R8: After any header the block hunts again and needs a complete new delimiter. Header bits are never searched for the delimiter.
- R9: Cycles with bit_valid low advance nothing: the search, the field capture and the CRC all wait, and no flag is raised on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Recovered serial bit |
| bit_valid | input | 1 | bit_in carries a new bit this cycle |
| hdr_good | output | 1 | One-cycle pulse: header passed |
| hdr_bad | output | 1 | One-cycle pulse: header failed |
| pay_len | output | 12 | Payload byte count from the last good header |
| rate_2m | output | 1 | 1 = 2 Mbps, 0 = 1 Mbps, from the last good header |
| arm_bits | output | 15 | Payload bit count (length x 8) for the payload counter |

## Verification
The assertions check four things on every cycle. The two flags never coincide, and the good pulse lasts a single cycle. The field outputs move only together with hdr_good. A flag only follows a cycle that carried a valid bit. The bench scenarios are needed to show the rest: delimiter matching in the presence of preamble, gaps in bit_valid, the field bit order, the 0x1D0F residue against a corrupted check word, rejection of an unknown rate code, and the return to hunting without a false resync inside a header that itself contains the delimiter pattern.

// File: rtl/plcp_hdr_rx.sv
module plcp_hdr_rx #(
  parameter int LEN_W = 12,
  parameter int SIG_W = 4,
  parameter int CRC_W = 16,
  parameter int DLM_W = 16,
  parameter logic [DLM_W-1:0] DLM = 16'h0CBD,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] RESIDUE = 16'h1D0F,
  parameter logic [SIG_W-1:0] SIG_1M = 4'b0000,
  parameter logic [SIG_W-1:0] SIG_2M = 4'b0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             bit_valid,
  output logic             hdr_good,
  output logic             hdr_bad,
  output logic [LEN_W-1:0] pay_len,
  output logic             rate_2m,
  output logic [LEN_W+2:0] arm_bits
);
  localparam int FLD_W = LEN_W + SIG_W;
  localparam int HDR_W = FLD_W + CRC_W;
  localparam int CNT_W = $clog2(HDR_W);

  logic             in_hdr;
  logic [CNT_W-1:0] cnt;
  logic [DLM_W-1:0] win;
  logic [CRC_W-1:0] crc;
  logic [FLD_W-1:0] fld;

  wire                 fb      = crc[CRC_W-1] ^ bit_in;
  wire [CRC_W-1:0]     crc_nx  = {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  wire [DLM_W-1:0]     win_nx  = {win[DLM_W-2:0], bit_in};
  wire [SIG_W-1:0]     sig     = fld[SIG_W-1:0];
  wire [LEN_W-1:0]     len     = fld[FLD_W-1:SIG_W];
  wire                 last    = in_hdr && (cnt == CNT_W'(HDR_W - 1));
  wire                 sig_ok  = (sig == SIG_1M) || (sig == SIG_2M);
  wire                 hdr_ok  = sig_ok && (crc_nx == RESIDUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_hdr   <= 1'b0;
      cnt      <= '0;
      win      <= '1;
      crc      <= '1;
      fld      <= '0;
      hdr_good <= 1'b0;
      hdr_bad  <= 1'b0;
      pay_len  <= '0;
      rate_2m  <= 1'b0;
      arm_bits <= '0;
    end else begin
      hdr_good <= 1'b0;
      hdr_bad  <= 1'b0;
      if (bit_valid) begin
        if (!in_hdr) begin
          win <= win_nx;
          if (win_nx == DLM) begin
            in_hdr <= 1'b1;
            cnt    <= '0;
            crc    <= '1;
          end
        end else begin
          crc <= crc_nx;
          cnt <= cnt + 1'b1;
          if (cnt < CNT_W'(FLD_W)) fld <= {fld[FLD_W-2:0], bit_in};
          if (last) begin
            in_hdr <= 1'b0;
            win    <= '1;
            if (hdr_ok) begin
              hdr_good <= 1'b1;
              pay_len  <= len;
              rate_2m  <= (sig == SIG_2M);
              arm_bits <= {len, 3'b000};
            end else begin
              hdr_bad  <= 1'b1;
            end
          end
        end
      end
    end
  end

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_good && hdr_bad)); // R6
  AST_GOOD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_good |=> !hdr_good); // R6
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_good |-> ($stable(pay_len) && $stable(rate_2m) && $stable(arm_bits))); // R7
  AST_FLAG_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_good || hdr_bad) |-> $past(bit_valid)); // R9
endmodule

// File: tb/plcp_hdr_rx_bench.sv
`timescale 1ns/1ps
module plcp_hdr_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic bit_valid = 1'b0;
  logic hdr_good, hdr_bad, rate_2m;
  logic [11:0] pay_len;
  logic [14:0] arm_bits;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int gap_ctr = 0;

  typedef struct {
    bit          good;
    logic [11:0] len;
    bit          rate;
    string       req;
  } exp_t;
  exp_t q[$];
  logic [11:0] held_len = '0;
  bit          held_rate = 1'b0;

  always #2.5 clk = ~clk;

  plcp_hdr_rx u_plcp_hdr_rx (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
    .hdr_good(hdr_good), .hdr_bad(hdr_bad), .pay_len(pay_len),
    .rate_2m(rate_2m), .arm_bits(arm_bits));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input bit b);
    logic f;
    f = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
  endfunction

  task automatic drive_bit(input bit b);
    if (gap_ctr % 7 == 3) begin
      @(posedge clk); #1;
      bit_valid = 1'b0;
      bit_in = ~b;
    end
    gap_ctr++;
    @(posedge clk); #1;
    bit_valid = 1'b1;
    bit_in = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bit_valid = 1'b0;
      bit_in = i[0];
    end
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) drive_bit(i[0]);
  endtask

  task automatic send_frame(input logic [11:0] len, input logic [3:0] sig,
                            input bit corrupt, input string req);
    logic [15:0] fld;
    logic [15:0] c;
    logic [15:0] hec;
    exp_t e;
    fld = {len, sig};
    c = 16'hFFFF;
    for (int i = 15; i >= 0; i--) c = crc_step(c, fld[i]);
    hec = ~c;
    if (corrupt) hec[5] = ~hec[5];
    e.good = !corrupt && (sig == 4'b0000 || sig == 4'b0010);
    if (e.good) begin
      held_len = len;
      held_rate = (sig == 4'b0010);
    end
    e.len = held_len;
    e.rate = held_rate;
    e.req = req;
    q.push_back(e);
    preamble(20);
    for (int i = 15; i >= 0; i--) drive_bit(16'h0CBD >> i);
    for (int i = 15; i >= 0; i--) drive_bit(fld[i]);
    for (int i = 15; i >= 0; i--) drive_bit(hec[i]);
    idle(3);
  endtask

  always @(negedge clk) begin
    if (rst_n && (hdr_good || hdr_bad)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8", "unexpected header flag", {hdr_good, hdr_bad}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(hdr_good == e.good && hdr_bad == !e.good, e.req, "good/bad flags",
            {hdr_good, hdr_bad}, {e.good, !e.good});
        chk(pay_len == e.len, "R7", "pay_len", pay_len, e.len);
        chk(rate_2m == e.rate, "R5", "rate_2m", rate_2m, e.rate);
        chk(arm_bits == {e.len, 3'b000}, "R7", "arm_bits", arm_bits, {e.len, 3'b000});
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!hdr_good && !hdr_bad, "R1", "flags after reset", {hdr_good, hdr_bad}, 0);
    chk(pay_len == 0, "R1", "pay_len after reset", pay_len, 0);
    chk(arm_bits == 0, "R1", "arm_bits after reset", arm_bits, 0);
    chk(rate_2m == 0, "R1", "rate after reset", rate_2m, 0);

    // R2: long preamble with gaps, no delimiter -> no flag
    preamble(200);
    idle(3);
    chk(q.size() == 0, "R2", "no event from preamble", q.size(), 0);

    send_frame(12'h123, 4'b0000, 1'b0, "R4");   // good, 1 Mbps, R3 bit order
    send_frame(12'hFFF, 4'b0010, 1'b0, "R5");   // good, 2 Mbps
    send_frame(12'h045, 4'b0000, 1'b1, "R4");   // corrupted check -> bad, held
    send_frame(12'h0CB, 4'b1101, 1'b0, "R8");   // header holds delimiter pattern, bad code
    preamble(60);                               // R8: no resync needed flag
    send_frame(12'h000, 4'b0010, 1'b0, "R3");   // zero length
    send_frame(12'h7A5, 4'b0001, 1'b0, "R5");   // unknown rate code
    send_frame(12'h800, 4'b0000, 1'b0, "R9");   // good, gaps throughout
    idle(10);
    chk(q.size() == 0, "R6", "every header flagged once", q.size(), 0);
    chk(pay_len == 12'h800, "R7", "final held length", pay_len, 12'h800);
    idle(5);
    chk(!hdr_good && !hdr_bad, "R9", "no flag while idle", {hdr_good, hdr_bad}, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule